// File: doc/BRIEF.md
# SPI Master with Word FIFOs

This block is a register-driven SPI bus master. Software writes transmit words into a small FIFO through a 32-bit register port. It chooses a word length from 1 to 32 bits, a clock idle level, a sampling phase and one of four chip-select lines. Setting the start bit then shifts one word out, most significant bit first. The bits captured from the slave are pushed, right-aligned, into a receive FIFO. Software reads that FIFO through a second data port.

Events are reported in one status register. A transfer in progress shows as busy, and a finished transfer raises the ready flag. FIFO misuse raises overflow or underrun flags. These event flags stay set until software writes a 1 to them, so writing back a value that was just read clears every pending event. The FIFO fill levels and empty/full flags are live values. The chip-select lines are active low. Software may hold the selected line down through a value bit, or leave the block to assert it only for the length of each transfer. The serial clock runs at the system clock divided by a build-time parameter.

Top module: `spi_link_master`

## Requirements
- R1: Register offsets are: control 0x000, select/enable 0x004, status 0x008, levels 0x01C, transmit port 0x100, receive port 0x180. After reset, control, select/enable and levels read 0, status reads 0x00A00000, all chip selects are high and SCLK is low.
- R2: A control write with bit 31 (enable) and bit 30 (start) set, while idle, pops the transmit head word. The block then drives its low N bits on MOSI, most significant first, over N SCLK cycles, where N = control[4:0] + 1. Bit 30 always reads back 0, and the other written control fields (bit 28, [25:24], 21, 12, 11, [4:0]) read back as written.
- R3: The N captured MISO bits go into the receive FIFO right-aligned with zeros above. Status bit 31 (busy) is 1 during the transfer. At its end bit 31 clears and bit 30 (ready) sets.
- R4: While idle, SCLK equals control bit 24. With control bit 21 = 0 the bus is sampled on the edge leaving the idle level. With bit 21 = 1 it is sampled on the edge returning to it.
- R5: Select/enable bits [19:18] pick chip-select line k. With control bit 11 = 1, control bit 12 = 1 drives line k low and 0 drives it high. With bit 11 = 0, line k is low only while busy. All other lines stay high, and at most one line is low at any time.
- R6: The transmit FIFO holds 4 words in order. A transmit-port write while it is full drops the word and sets status bit 19. Status bit 20 shows full and bit 21 shows empty.
- R7: A receive-port read while the receive FIFO is empty returns 0 and sets status bit 18. Status bit 23 shows receive empty.
- R8: A transfer that completes with the receive FIFO full drops the new word and sets status bit 25. Status bit 22 shows receive full.
- R9: A start request with transmit enabled and the transmit FIFO empty starts no transfer and sets status bit 24.
- R10: A status write clears each of bits 30, 25, 24, 19 and 18 where it holds a 1. Zeros leave those bits unchanged, and the live bits 31 and 23..20 are unaffected.
- R11: The levels register holds the receive FIFO count in bits [18:16] and the transmit FIFO count in bits [2:0].
- R12: A start request while busy, or with control bit 31 clear, is ignored and pops nothing.
- R13: With select/enable bit 31 = 0 no received word is stored. With bit 30 = 0 nothing is popped and zeros are shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive port) |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 4 | Active-low chip-select lines |

## Verification
Checks run on every cycle hold the following. At most one select line is low. SCLK follows the programmed idle level whenever no transfer runs. A finished transfer always leaves ready set and busy clear. A full-FIFO write or an empty-FIFO read always leaves the matching sticky flag set. The FIFO levels never exceed their depth. Bit order, the choice of sampling edge, right alignment, FIFO ordering, dropped words, ignored start requests and the effect of the direction enables can only be shown by the directed scenarios. These scenarios loop MOSI back to MISO and decode the serial stream independently.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

    localparam logic [8:0] A_CTRL  = 9'h000;
    localparam logic [8:0] A_SEL   = 9'h004;
    localparam logic [8:0] A_STAT  = 9'h008;
    localparam logic [8:0] A_LEVEL = 9'h01C;
    localparam logic [8:0] A_TXP   = 9'h100;
    localparam logic [8:0] A_RXP   = 9'h180;

    // control register bit positions
    localparam int C_EN     = 31;
    localparam int C_GO     = 30;
    localparam int C_MASTER = 28;
    localparam int C_IDLE   = 24;
    localparam int C_PHASE  = 21;
    localparam int C_CSVAL  = 12;
    localparam int C_CSSOFT = 11;

    // select/enable register bit positions
    localparam int S_RXEN = 31;
    localparam int S_TXEN = 30;
    localparam int S_IDX  = 18;

    // status register bit positions
    localparam int F_BUSY   = 31;
    localparam int F_READY  = 30;
    localparam int F_RXOVF  = 25;
    localparam int F_TXUNR  = 24;
    localparam int F_RXEMP  = 23;
    localparam int F_RXFULL = 22;
    localparam int F_TXEMP  = 21;
    localparam int F_TXFULL = 20;
    localparam int F_TXOVF  = 19;
    localparam int F_RXUNR  = 18;

    typedef struct packed {
        logic       enable;
        logic       master;
        logic [1:0] idle;
        logic       phase;
        logic       cs_val;
        logic       cs_soft;
        logic [4:0] len_m1;
    } ctrl_t;

    typedef struct packed {
        logic ready;
        logic rx_ovf;
        logic tx_unr;
        logic tx_ovf;
        logic rx_unr;
    } sticky_t;

endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t q, d;
    logic  push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CNT_W'(DEPTH));
    assign count = q.cnt;
    assign rdata = q.mem[q.rd];

    always_comb begin
        d       = q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            d.mem[q.wr] = wdata;
            d.wr        = bump(q.wr);
        end
        if (pop_ok) begin
            d.rd = bump(q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: level never exceeds the storage depth
    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH));

    // R7: an empty FIFO is never popped by its owner
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
    parameter int DATA_W  = 32,
    parameter int CLK_DIV = 2,
    parameter int LEN_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [DATA_W-1:0] word,
    input  logic              phase_in,
    input  logic              idle_hi,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi
);

    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int EDGE_W = LEN_W + 1;

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              phase;
        logic [DIV_W-1:0]  div;
        logic [EDGE_W-1:0] edge_cnt;
        logic [EDGE_W-1:0] last;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.busy) begin
            d.sclk = idle_hi;
            if (start) begin
                d.busy     = 1'b1;
                d.div      = '0;
                d.edge_cnt = '0;
                d.last     = {len_m1, 1'b1};
                d.phase    = phase_in;
                d.tx       = word << (LEN_W'(DATA_W - 1) - len_m1);
                d.rx       = '0;
            end
        end else if (q.div == DIV_W'(CLK_DIV - 1)) begin
            d.div      = '0;
            d.sclk     = ~q.sclk;
            d.edge_cnt = q.edge_cnt + 1'b1;
            if (q.edge_cnt[0] == q.phase) begin
                d.rx = {q.rx[DATA_W-2:0], miso};
            end else if (q.edge_cnt != '0) begin
                d.tx = q.tx << 1;
            end
            if (q.edge_cnt == q.last) begin
                d.busy = 1'b0;
                done   = 1'b1;
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sclk    = q.sclk;
    assign mosi    = q.tx[DATA_W-1];
    assign rx_word = d.rx;

    // R4: with no transfer running, the clock settles to the idle level
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |=> (q.sclk == $past(idle_hi)));

    // R3: the end of a transfer always drops busy
    p_done_drops_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !q.busy);

endmodule

// File: rtl/spi_link_master.sv
`timescale 1ns/1ps
module spi_link_master #(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 2,
    parameter int NUM_CS     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [8:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  spi_cs_n
);

    import spim_pkg::*;

    localparam int LEN_W = $clog2(DATA_W);
    localparam int SEL_W = $clog2(NUM_CS);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             rxen;
        logic             txen;
        logic [SEL_W-1:0] cs_idx;
        sticky_t          st;
    } regs_t;

    regs_t q, d;

    logic              wr_ctrl, wr_sel, wr_stat, wr_tx, rd_rx;
    logic              go_req, xfer_start;
    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic              tx_ovf_evt, tx_unr_evt, rx_ovf_evt, rx_unr_evt;
    logic [DATA_W-1:0] tx_head, rx_head, sh_word, sh_rx;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              sh_busy, sh_done, sh_idle;
    logic              cs_drive;

    // bus decode and event generation
    always_comb begin
        wr_ctrl    = reg_wr && (reg_addr == A_CTRL);
        wr_sel     = reg_wr && (reg_addr == A_SEL);
        wr_stat    = reg_wr && (reg_addr == A_STAT);
        wr_tx      = reg_wr && (reg_addr == A_TXP);
        rd_rx      = reg_rd && (reg_addr == A_RXP);
        go_req     = wr_ctrl && reg_wdata[C_GO] && reg_wdata[C_EN];
        xfer_start = go_req && !sh_busy && (!q.txen || !tx_empty);
        tx_unr_evt = go_req && !sh_busy && q.txen && tx_empty;
        tx_pop     = xfer_start && q.txen;
        tx_push    = wr_tx && !tx_full;
        tx_ovf_evt = wr_tx && tx_full;
        rx_pop     = rd_rx && !rx_empty;
        rx_unr_evt = rd_rx && rx_empty;
        rx_push    = sh_done && q.rxen && !rx_full;
        rx_ovf_evt = sh_done && q.rxen && rx_full;
        sh_word    = q.txen ? tx_head : '0;
        sh_idle    = wr_ctrl ? reg_wdata[C_IDLE] : q.ctrl.idle[0];
    end

    // next register state
    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.ctrl.enable  = reg_wdata[C_EN];
            d.ctrl.master  = reg_wdata[C_MASTER];
            d.ctrl.idle    = reg_wdata[C_IDLE+1:C_IDLE];
            d.ctrl.phase   = reg_wdata[C_PHASE];
            d.ctrl.cs_val  = reg_wdata[C_CSVAL];
            d.ctrl.cs_soft = reg_wdata[C_CSSOFT];
            d.ctrl.len_m1  = reg_wdata[4:0];
        end
        if (wr_sel) begin
            d.rxen   = reg_wdata[S_RXEN];
            d.txen   = reg_wdata[S_TXEN];
            d.cs_idx = reg_wdata[S_IDX +: SEL_W];
        end
        if (wr_stat) begin
            d.st.ready  = q.st.ready  & ~reg_wdata[F_READY];
            d.st.rx_ovf = q.st.rx_ovf & ~reg_wdata[F_RXOVF];
            d.st.tx_unr = q.st.tx_unr & ~reg_wdata[F_TXUNR];
            d.st.tx_ovf = q.st.tx_ovf & ~reg_wdata[F_TXOVF];
            d.st.rx_unr = q.st.rx_unr & ~reg_wdata[F_RXUNR];
        end
        if (sh_done)    d.st.ready  = 1'b1;
        if (rx_ovf_evt) d.st.rx_ovf = 1'b1;
        if (tx_unr_evt) d.st.tx_unr = 1'b1;
        if (tx_ovf_evt) d.st.tx_ovf = 1'b1;
        if (rx_unr_evt) d.st.rx_unr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // read data
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_EN]              = q.ctrl.enable;
                reg_rdata[C_MASTER]          = q.ctrl.master;
                reg_rdata[C_IDLE+1:C_IDLE]   = q.ctrl.idle;
                reg_rdata[C_PHASE]           = q.ctrl.phase;
                reg_rdata[C_CSVAL]           = q.ctrl.cs_val;
                reg_rdata[C_CSSOFT]          = q.ctrl.cs_soft;
                reg_rdata[4:0]               = q.ctrl.len_m1;
            end
            A_SEL: begin
                reg_rdata[S_RXEN]            = q.rxen;
                reg_rdata[S_TXEN]            = q.txen;
                reg_rdata[S_IDX +: SEL_W]    = q.cs_idx;
            end
            A_STAT: begin
                reg_rdata[F_BUSY]   = sh_busy;
                reg_rdata[F_READY]  = q.st.ready;
                reg_rdata[F_RXOVF]  = q.st.rx_ovf;
                reg_rdata[F_TXUNR]  = q.st.tx_unr;
                reg_rdata[F_RXEMP]  = rx_empty;
                reg_rdata[F_RXFULL] = rx_full;
                reg_rdata[F_TXEMP]  = tx_empty;
                reg_rdata[F_TXFULL] = tx_full;
                reg_rdata[F_TXOVF]  = q.st.tx_ovf;
                reg_rdata[F_RXUNR]  = q.st.rx_unr;
            end
            A_LEVEL: begin
                reg_rdata[16 +: CNT_W] = rx_cnt;
                reg_rdata[0 +: CNT_W]  = tx_cnt;
            end
            A_RXP:   reg_rdata = rx_empty ? '0 : rx_head;
            default: reg_rdata = '0;
        endcase
    end

    // chip-select lines
    assign cs_drive = q.ctrl.cs_soft ? q.ctrl.cs_val : sh_busy;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign spi_cs_n[i] = !(cs_drive && (q.cs_idx == SEL_W'(i)));
    end

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (reg_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (sh_rx),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spim_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .len_m1   (reg_wdata[LEN_W-1:0]),
        .word     (sh_word),
        .phase_in (reg_wdata[C_PHASE]),
        .idle_hi  (sh_idle),
        .miso     (spi_miso),
        .busy     (sh_busy),
        .done     (sh_done),
        .rx_word  (sh_rx),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi)
    );

    // R5: never more than one select line low
    p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R3: a finished transfer leaves ready set and busy clear
    p_done_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> (q.st.ready && !sh_busy));

    // R6: writing a full transmit FIFO flags overflow
    p_tx_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full) |=> q.st.tx_ovf);

    // R7: reading an empty receive FIFO flags underrun
    p_rx_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty) |=> q.st.rx_unr);

    // R12: a start request while busy never pops the transmit FIFO
    p_busy_no_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && sh_busy) |=> $stable(tx_cnt) || (tx_cnt > $past(tx_cnt)));

endmodule

// File: tb/test_spi_link_master.sv
`timescale 1ns/1ps
module test_spi_link_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;

    logic        miso_force = 1'b0;
    logic        miso_val = 1'b0;
    assign spi_miso = miso_force ? miso_val : spi_mosi;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    spi_link_master i_spi_link_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    // independent slave-side decoder of the serial stream
    logic        b_idle = 1'b0;
    logic        b_phase = 1'b0;
    int          mon_cnt = 0;
    logic [31:0] mon_cap = '0;

    always @(spi_sclk) begin
        if (rst_n && ((spi_sclk == b_idle) == b_phase)) begin
            mon_cap = {mon_cap[30:0], spi_mosi};
            mon_cnt = mon_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [8:0] CTRL = 9'h000, SEL = 9'h004, STAT = 9'h008;
    localparam logic [8:0] LVL = 9'h01C, TXP = 9'h100, RXP = 9'h180;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit go, input int len, input bit idle, input bit ph);
        return 32'h9000_0000 | (32'(go) << 30) | (32'(idle) << 24) | (32'(ph) << 21) | 32'(len - 1);
    endfunction

    function automatic logic [31:0] mask(input int len);
        return (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(STAT, v);
            if (!v[31]) break;
        end
    endtask

    task automatic arm(input int len, input bit idle, input bit ph);
        wr(CTRL, mk_ctrl(0, len, idle, ph));
        b_idle = idle; b_phase = ph;
        mon_cnt = 0; mon_cap = '0;
        wr(CTRL, mk_ctrl(1, len, idle, ph));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(CTRL, v);  chk("R1 control reset", v, 32'h0);
        rd(SEL, v);   chk("R1 select reset", v, 32'h0);
        rd(STAT, v);  chk("R1 status reset", v, 32'h00A0_0000);
        rd(LVL, v);   chk("R1 levels reset", v, 32'h0);
        chk("R1 cs reset", 32'(spi_cs_n), 32'hF);
        chk("R1 sclk reset", 32'(spi_sclk), 32'h0);
    endtask

    task automatic t_xfer(input int len, input bit idle, input bit ph, input logic [31:0] w);
        logic [31:0] v;
        wr(TXP, w);
        arm(len, idle, ph);
        if (len >= 8) begin
            rd(STAT, v); chk("R3 busy during transfer", 32'(v[31]), 32'h1);
        end
        wait_idle();
        chk("R2 clock count", 32'(mon_cnt), 32'(len));
        chk("R2 MOSI bits msb first", mon_cap & mask(len), w & mask(len));
        rd(STAT, v);  chk("R3 busy clear ready set", v & 32'hC000_0000, 32'h4000_0000);
        rd(RXP, v);   chk("R3 received word right-aligned", v, w & mask(len));
        chk("R4 sclk at idle level", 32'(spi_sclk), 32'(idle));
        rd(CTRL, v);  chk("R2 start bit self clears", v, mk_ctrl(0, len, idle, ph));
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_miso_ones();
        logic [31:0] v;
        miso_force = 1'b1; miso_val = 1'b1;
        wr(TXP, 32'h0);
        arm(5, 0, 0);
        wait_idle();
        rd(RXP, v); chk("R3 zeros above captured bits", v, 32'h0000_001F);
        miso_force = 1'b0; miso_val = 1'b0;
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_cs();
        logic [31:0] v;
        wr(SEL, 32'hC000_0000 | (32'd2 << 18));
        wr(CTRL, 32'h0000_1800);
        chk("R5 soft select low", 32'(spi_cs_n), 32'hB);
        wr(CTRL, 32'h0000_0800);
        chk("R5 soft select released", 32'(spi_cs_n), 32'hF);
        wr(SEL, 32'hC000_0000 | (32'd1 << 18));
        wr(TXP, 32'h0F0F_0F0F);
        arm(32, 0, 0);
        @(negedge clk);
        chk("R5 hardware select during transfer", 32'(spi_cs_n), 32'hD);
        wait_idle();
        chk("R5 hardware select after transfer", 32'(spi_cs_n), 32'hF);
        rd(RXP, v);
        wr(SEL, 32'hC000_0000);
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_fifo_limits();
        logic [31:0] v;
        for (int i = 1; i <= 5; i++) wr(TXP, 32'(i));
        rd(LVL, v);  chk("R11 transmit level", v, 32'h0000_0004);
        rd(STAT, v); chk("R6 full and overflow", v & 32'h0018_0000, 32'h0018_0000);
        wr(STAT, 32'h0);
        rd(STAT, v); chk("R10 zero write keeps flag", 32'(v[19]), 32'h1);
        wr(STAT, 32'h0008_0000);
        rd(STAT, v); chk("R10 one clears flag only", v & 32'h0018_0000, 32'h0010_0000);
        for (int i = 1; i <= 4; i++) begin
            arm(8, 0, 0);
            wait_idle();
            chk("R6 transmit order", mon_cap & 32'hFF, 32'(i));
        end
        wr(TXP, 32'h66);
        arm(8, 0, 0);
        wait_idle();
        rd(STAT, v); chk("R8 receive overflow and full", v & 32'h0240_0000, 32'h0240_0000);
        rd(LVL, v);  chk("R11 receive level", v, 32'h0004_0000);
        rd(RXP, v);  chk("R8 newest word dropped", v, 32'h1);
        for (int i = 2; i <= 4; i++) begin
            rd(RXP, v); chk("R6 receive order", v, 32'(i));
        end
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, v); chk("R10 live bits unaffected", v, 32'h00A0_0000);
    endtask

    task automatic t_underruns();
        logic [31:0] v;
        rd(RXP, v);  chk("R7 empty read returns zero", v, 32'h0);
        rd(STAT, v); chk("R7 underrun flag", 32'(v[18]), 32'h1);
        wr(STAT, 32'hFFFF_FFFF);
        wr(CTRL, mk_ctrl(1, 8, 0, 0));
        rd(STAT, v); chk("R9 start with empty FIFO", v & 32'h8100_0000, 32'h0100_0000);
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_ignored_start();
        logic [31:0] v;
        wr(TXP, 32'h7);
        wr(CTRL, 32'h4000_0007);
        rd(STAT, v); chk("R12 disabled start not busy", 32'(v[31]), 32'h0);
        rd(LVL, v);  chk("R12 disabled start pops nothing", v, 32'h0000_0001);
        arm(32, 0, 0);
        wr(TXP, 32'h8);
        wr(CTRL, mk_ctrl(1, 8, 0, 0));
        wait_idle();
        rd(LVL, v);  chk("R12 start while busy ignored", v, 32'h0001_0001);
        rd(RXP, v);  chk("R12 first transfer kept its length", v, 32'h7);
        arm(8, 0, 0);
        wait_idle();
        rd(RXP, v);
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_directions();
        logic [31:0] v;
        wr(SEL, 32'h4000_0000);
        wr(TXP, 32'h55);
        arm(8, 0, 0);
        wait_idle();
        rd(LVL, v);  chk("R13 receive disabled stores nothing", v, 32'h0);
        wr(SEL, 32'h8000_0000);
        wr(TXP, 32'h77);
        arm(8, 1, 1);
        wait_idle();
        chk("R13 transmit disabled shifts zeros", mon_cap & 32'hFF, 32'h0);
        rd(LVL, v);  chk("R13 transmit disabled pops nothing", v, 32'h0001_0001);
        rd(RXP, v);  chk("R13 zero word received", v, 32'h0);
        wr(SEL, 32'hC000_0000);
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        wr(SEL, 32'hC000_0000);
        t_xfer(8, 0, 0, 32'h0000_00A5);
        t_xfer(32, 1, 1, 32'hDEAD_BEEF);
        t_xfer(1, 0, 1, 32'h0000_0001);
        t_xfer(13, 1, 0, 32'h1234_5ABC);
        t_xfer(17, 0, 1, 32'h0001_6C3A);
        t_miso_ones();
        t_cs();
        t_fifo_limits();
        t_underruns();
        t_ignored_start();
        t_directions();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule